// File: doc/BRIEF.md
# Two-Level Breakpoint Trigger Unit

This block watches three processor buses on every cycle in which `obs_valid` is high: the program counter, the operand address and the operand data. Four comparators test them. One checks the program counter under a don't-care mask. One checks it for exact equality. One checks whether the operand address lies inside an inclusive window. One checks the data under a don't-care mask. A control register gives each comparator an enable and places it in a first-level group, a second-level group, or both. It also chooses whether the trigger fires on one level or on a two-step sequence, and which response a trigger produces.

The response is one of three. It can be a one-cycle status pulse for the debug data output, a one-cycle halt request, or a one-cycle debug interrupt. The present breakpoint state is always visible on `brk_state`. Software writes all configuration through a plain register write port. Every write to the control register rearms the unit. The observed buses are sampled and never stalled, so neither port has a ready signal and no back-pressure exists. A write is accepted in every cycle in which `cfg_wr_en` is high.

Top module: `brk_trigger_unit`

## Requirements
- R1: After reset `brk_state` is 0 (idle), and `halt_req`, `dbg_irq` and `stat_pulse` are low.
- R2: The masked PC comparator matches when `((obs_pc ^ value) & ~mask) == 0`, so a mask bit of 1 makes that bit don't-care. The value is at register address 1 and the mask at address 2.
- R3: The exact PC comparator matches only when `obs_pc` equals the value at register address 3.
- R4: The range comparator matches when `low <= obs_addr <= high`, both bounds inclusive. The low bound is at address 4 and the high bound at address 5.
- R5: The masked data comparator matches when `((obs_data ^ value) & ~mask) == 0`. The value is at address 6 and the mask at address 7.
- R6: A comparator whose enable bit is 0 never contributes a match. No comparator matches in a cycle with `obs_valid` low.
- R7: The control register is at address 0. Its fields are: bits [3:0] enable (bit 0 masked PC, bit 1 exact PC, bit 2 range, bit 3 data); bits [7:4] level-1 select; bits [11:8] level-2 select; bit 12 two-level mode; bits [14:13] response. A level matches when any enabled comparator in its select set matches.
- R8: In one-level mode, a level-1 match while `brk_state` is 1 (armed) moves it to 3 (triggered) and fires the response.
- R9: In two-level mode, a level-1 match while armed moves the state to 2 (level-1 hit) without a response. A later level-2 match moves it to 3 and fires the response. A level-2 match in the same cycle as the level-1 match, or before it, does not count.
- R10: The response code 1 gives `halt_req`, code 2 gives `dbg_irq`, and codes 0 and 3 give `stat_pulse`. Each is a one-cycle pulse in the cycle after the triggering sample, and only one of them is high at a time.
- R11: State 3 holds, with no further pulses, until the next control register write.
- R12: A control register write sets the state to 1 in the next cycle. When it coincides with a matching sample, the write wins and no response fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 3 | Register address |
| cfg_wr_data | input | WR_W | Write data; WR_W is the larger of DW and 16 |
| obs_valid | input | 1 | Observed buses carry a valid sample this cycle |
| obs_pc | input | DW | Program counter sample |
| obs_addr | input | DW | Operand address sample |
| obs_data | input | DW | Operand data sample |
| brk_state | output | 2 | 0 idle, 1 armed, 2 level-1 hit, 3 triggered |
| halt_req | output | 1 | One-cycle halt request |
| dbg_irq | output | 1 | One-cycle debug interrupt |
| stat_pulse | output | 1 | One-cycle status-only trigger indication |

## Verification
Two functions can fall in the same cycle. A rearming control write can land on a sample that would trigger, and in two-level mode a level-1 match can arrive together with a level-2 match. The bench drives both cases on purpose. In the first, it presents the write and a fully matching sample on the same edge, then expects state 1 and no pulse. In the second, it presents a sample that satisfies both levels while the unit is armed, then expects state 2 with no pulse, and requires a separate later level-2 sample before the response appears. The comparator functions are swept over every 8-bit input value and judged against arithmetic masks and bounds.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NUM_CMP = 4;
  localparam int CMP_PCM = 0;
  localparam int CMP_PCX = 1;
  localparam int CMP_RNG = 2;
  localparam int CMP_DAT = 3;
  localparam int CTRL_W  = 15;

  localparam int KIND_MASKED = 0;
  localparam int KIND_RANGE  = 1;

  localparam logic [2:0] RA_CTRL = 3'd0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_L1HIT = 2'd2,
    ST_TRIG  = 2'd3
  } brk_state_e;

  typedef enum logic [1:0] {
    ACT_STATUS = 2'd0,
    ACT_HALT   = 2'd1,
    ACT_IRQ    = 2'd2,
    ACT_STAT2  = 2'd3
  } brk_act_e;

  typedef struct packed {
    brk_act_e             action;
    logic                 two_lvl;
    logic [NUM_CMP-1:0]   l2_sel;
    logic [NUM_CMP-1:0]   l1_sel;
    logic [NUM_CMP-1:0]   en;
  } brk_ctrl_t;
endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
  import brk_pkg::*;
#(
  parameter int DW   = 32,
  parameter int WR_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [WR_W-1:0] wr_data,
  output brk_ctrl_t       ctrl,
  output logic            ctrl_wr,
  output logic [DW-1:0]   pcm_val,
  output logic [DW-1:0]   pcm_mask,
  output logic [DW-1:0]   pcx_val,
  output logic [DW-1:0]   rng_lo,
  output logic [DW-1:0]   rng_hi,
  output logic [DW-1:0]   dat_val,
  output logic [DW-1:0]   dat_mask
);
  localparam int NREG = 7;

  logic [DW-1:0] regs_q [NREG];

  assign ctrl_wr = wr_en && (wr_addr == RA_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (ctrl_wr) ctrl <= brk_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else if (wr_en && (wr_addr == 3'(g + 1))) regs_q[g] <= wr_data[DW-1:0];
    end
  end

  assign pcm_val  = regs_q[0];
  assign pcm_mask = regs_q[1];
  assign pcx_val  = regs_q[2];
  assign rng_lo   = regs_q[3];
  assign rng_hi   = regs_q[4];
  assign dat_val  = regs_q[5];
  assign dat_mask = regs_q[6];

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl == brk_ctrl_t'($past(wr_data[CTRL_W-1:0])))); // R7
  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl)); // R7
endmodule

// File: rtl/brk_cmp.sv
module brk_cmp
  import brk_pkg::*;
#(
  parameter int W    = 32,
  parameter int KIND = KIND_MASKED
) (
  input  logic [W-1:0] sample,
  input  logic [W-1:0] ref_a,
  input  logic [W-1:0] ref_b,
  output logic         hit
);
  if (KIND == KIND_RANGE) begin : g_range
    always_comb hit = (sample >= ref_a) && (sample <= ref_b);
  end else begin : g_masked
    always_comb hit = ((sample ^ ref_a) & ~ref_b) == '0;
  end
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  brk_ctrl_t          ctrl,
  input  logic               ctrl_wr,
  input  logic [NUM_CMP-1:0] hits,
  output brk_state_e         state_q,
  output logic               halt_req,
  output logic               dbg_irq,
  output logic               stat_pulse
);
  brk_state_e state_d;
  logic       l1_hit, l2_hit, fire;

  always_comb begin
    l1_hit  = |(hits & ctrl.l1_sel);
    l2_hit  = |(hits & ctrl.l2_sel);
    state_d = state_q;
    fire    = 1'b0;
    if (ctrl_wr) begin
      state_d = ST_ARMED;
    end else begin
      unique case (state_q)
        ST_ARMED: if (l1_hit) begin
          if (ctrl.two_lvl) state_d = ST_L1HIT;
          else begin
            state_d = ST_TRIG;
            fire    = 1'b1;
          end
        end
        ST_L1HIT: if (l2_hit) begin
          state_d = ST_TRIG;
          fire    = 1'b1;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      halt_req   <= 1'b0;
      dbg_irq    <= 1'b0;
      stat_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      halt_req   <= fire && (ctrl.action == ACT_HALT);
      dbg_irq    <= fire && (ctrl.action == ACT_IRQ);
      stat_pulse <= fire && ((ctrl.action == ACT_STATUS) || (ctrl.action == ACT_STAT2));
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, dbg_irq, stat_pulse})); // R10
  AST_HALT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req); // R10
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |=> !dbg_irq); // R10
  AST_PULSE_IN_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq || stat_pulse) |-> (state_q == ST_TRIG)); // R10
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIG && !ctrl_wr) |=> (state_q == ST_TRIG && !halt_req && !dbg_irq && !stat_pulse)); // R11
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (state_q == ST_ARMED && !halt_req && !dbg_irq && !stat_pulse)); // R12
  AST_NO_SKIP_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.two_lvl && state_q == ST_ARMED && !ctrl_wr) |=> (state_q != ST_TRIG)); // R9
endmodule

// File: rtl/brk_trigger_unit.sv
module brk_trigger_unit
  import brk_pkg::*;
#(
  parameter int DW = 32,
  localparam int WR_W = (DW > 16) ? DW : 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [2:0]      cfg_wr_addr,
  input  logic [WR_W-1:0] cfg_wr_data,
  input  logic            obs_valid,
  input  logic [DW-1:0]   obs_pc,
  input  logic [DW-1:0]   obs_addr,
  input  logic [DW-1:0]   obs_data,
  output logic [1:0]      brk_state,
  output logic            halt_req,
  output logic            dbg_irq,
  output logic            stat_pulse
);
  brk_ctrl_t          ctrl;
  logic               ctrl_wr;
  logic [DW-1:0]      pcm_val, pcm_mask, pcx_val, rng_lo, rng_hi, dat_val, dat_mask;
  logic [NUM_CMP-1:0] raw_hit, hits;
  brk_state_e         state_q;

  brk_cfg_regs #(.DW(DW), .WR_W(WR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
    .ctrl(ctrl), .ctrl_wr(ctrl_wr),
    .pcm_val(pcm_val), .pcm_mask(pcm_mask), .pcx_val(pcx_val),
    .rng_lo(rng_lo), .rng_hi(rng_hi), .dat_val(dat_val), .dat_mask(dat_mask)
  );

  brk_cmp #(.W(DW), .KIND(KIND_MASKED)) u_cmp_pcm (
    .sample(obs_pc), .ref_a(pcm_val), .ref_b(pcm_mask), .hit(raw_hit[CMP_PCM]));
  brk_cmp #(.W(DW), .KIND(KIND_MASKED)) u_cmp_pcx (
    .sample(obs_pc), .ref_a(pcx_val), .ref_b('0), .hit(raw_hit[CMP_PCX]));
  brk_cmp #(.W(DW), .KIND(KIND_RANGE)) u_cmp_rng (
    .sample(obs_addr), .ref_a(rng_lo), .ref_b(rng_hi), .hit(raw_hit[CMP_RNG]));
  brk_cmp #(.W(DW), .KIND(KIND_MASKED)) u_cmp_dat (
    .sample(obs_data), .ref_a(dat_val), .ref_b(dat_mask), .hit(raw_hit[CMP_DAT]));

  assign hits = raw_hit & ctrl.en & {NUM_CMP{obs_valid}};

  brk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ctrl_wr(ctrl_wr), .hits(hits),
    .state_q(state_q), .halt_req(halt_req), .dbg_irq(dbg_irq), .stat_pulse(stat_pulse)
  );

  assign brk_state = state_q;

  AST_GATED_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (hits & ~ctrl.en) == '0 && (obs_valid || hits == '0)); // R6
  AST_RANGE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    raw_hit[CMP_RNG] |-> (obs_addr >= rng_lo && obs_addr <= rng_hi)); // R4
endmodule

// File: tb/brk_trigger_unit_tb.sv
module brk_trigger_unit_tb;
  localparam int DW = 8;
  localparam int WW = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cfg_wr_en = 0;
  logic [2:0]    cfg_wr_addr = '0;
  logic [WW-1:0] cfg_wr_data = '0;
  logic          obs_valid = 0;
  logic [DW-1:0] obs_pc = '0, obs_addr = '0, obs_data = '0;
  logic [1:0]    brk_state;
  logic          halt_req, dbg_irq, stat_pulse;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  brk_trigger_unit #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .obs_valid(obs_valid), .obs_pc(obs_pc),
    .obs_addr(obs_addr), .obs_data(obs_data), .brk_state(brk_state),
    .halt_req(halt_req), .dbg_irq(dbg_irq), .stat_pulse(stat_pulse));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] ctl(input logic [3:0] en, input logic [3:0] l1,
                                        input logic [3:0] l2, input bit two, input logic [1:0] act);
    return WW'({act, two, l2, l1, en});
  endfunction

  task automatic wr(input logic [2:0] a, input logic [WW-1:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  // drive one sample; return at the negedge after the sampling edge
  task automatic smp(input logic [DW-1:0] pc, input logic [DW-1:0] ad, input logic [DW-1:0] da);
    obs_valid = 1; obs_pc = pc; obs_addr = ad; obs_data = da;
    @(negedge clk);
    obs_valid = 0;
  endtask

  function automatic int rsp(input logic [1:0] act);
    return {29'd0, halt_req, dbg_irq, stat_pulse} & ((act == 2'd1) ? 4 : (act == 2'd2) ? 2 : 1);
  endfunction

  task automatic sweep(input string req, input int kind, input logic [WW-1:0] c,
                       input logic [1:0] act, input int p, input int q);
    for (int v = 0; v < 256; v++) begin
      bit exp;
      wr(3'd0, c);
      case (kind)
        0: exp = ((v ^ p) & ~q & 8'hFF) == 0;
        1: exp = (v == p);
        2: exp = (v >= p) && (v <= q);
        default: exp = ((v ^ p) & ~q & 8'hFF) == 0;
      endcase
      case (kind)
        0, 1: smp(8'(v), 8'h00, 8'h00);
        2: smp(8'h00, 8'(v), 8'h00);
        default: smp(8'h00, 8'h00, 8'(v));
      endcase
      chk((rsp(act) != 0) == exp && brk_state == (exp ? 2'd3 : 2'd1) &&
          $countones({halt_req, dbg_irq, stat_pulse}) == int'(exp), req,
          {brk_state, halt_req, dbg_irq, stat_pulse}, exp);
    end
  endtask

  initial begin
    fork
      begin
        #1990000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk(brk_state == 0 && !halt_req && !dbg_irq && !stat_pulse, "R1", brk_state, 0);
    rst_n = 1;
    @(negedge clk);
    chk(brk_state == 0, "R1", brk_state, 0);

    // R2: masked PC, irq response
    wr(3'd1, 16'h00A5); wr(3'd2, 16'h000F);
    sweep("R2", 0, ctl(4'b0001, 4'b0001, 4'b0000, 0, 2'd2), 2'd2, 'hA5, 'h0F);
    // R3: exact PC, status response (code 0)
    wr(3'd3, 16'h003C);
    sweep("R3", 1, ctl(4'b0010, 4'b0010, 4'b0000, 0, 2'd0), 2'd0, 'h3C, 0);
    // R4: inclusive range, halt response
    wr(3'd4, 16'h0030); wr(3'd5, 16'h0050);
    sweep("R4", 2, ctl(4'b0100, 4'b0100, 4'b0000, 0, 2'd1), 2'd1, 'h30, 'h50);
    wr(3'd4, 16'h0077); wr(3'd5, 16'h0077);
    sweep("R4", 2, ctl(4'b0100, 4'b0100, 4'b0000, 0, 2'd1), 2'd1, 'h77, 'h77);
    // R5: masked data, code 3 gives status
    wr(3'd6, 16'h0081); wr(3'd7, 16'h0070);
    sweep("R5", 3, ctl(4'b1000, 4'b1000, 4'b0000, 0, 2'd3), 2'd3, 'h81, 'h70);

    // R6: all selected but none enabled; range 0..FF matches everything
    wr(3'd4, 16'h0000); wr(3'd5, 16'h00FF);
    for (int v = 0; v < 256; v += 17) begin
      wr(3'd0, ctl(4'b0000, 4'b1111, 4'b0000, 0, 2'd1));
      smp(8'(v), 8'(v), 8'(v));
      chk(brk_state == 1 && !halt_req, "R6", brk_state, 1);
    end
    // R6: enabled but obs_valid low
    wr(3'd0, ctl(4'b0100, 4'b0100, 4'b0000, 0, 2'd1));
    obs_addr = 8'h10; @(negedge clk); @(negedge clk);
    chk(brk_state == 1 && !halt_req, "R6", brk_state, 1);
    // R7: level 1 from any enabled selected comparator (range only enabled of two)
    wr(3'd0, ctl(4'b0100, 4'b0110, 4'b0000, 0, 2'd1));
    smp(8'h00, 8'h42, 8'h00);
    chk(brk_state == 3 && halt_req, "R7", brk_state, 3);

    // R8 / R10: one-level halt, pulse lasts one cycle
    wr(3'd0, ctl(4'b0100, 4'b0100, 4'b0000, 0, 2'd1));
    smp(8'h00, 8'h20, 8'h00);
    chk(brk_state == 3 && halt_req, "R8", brk_state, 3);
    @(negedge clk);
    chk(!halt_req && !dbg_irq && !stat_pulse, "R10", halt_req, 0);
    // R11: stays triggered, no more pulses
    smp(8'h00, 8'h21, 8'h00);
    chk(brk_state == 3 && !halt_req, "R11", {brk_state, halt_req}, 6);

    // R9: two-level; L1 = exact PC 0x3C, L2 = masked data 0x81/0x70
    wr(3'd0, ctl(4'b1010, 4'b0010, 4'b1000, 1, 2'd2));
    smp(8'h00, 8'h00, 8'h81);
    chk(brk_state == 1 && !dbg_irq, "R9", brk_state, 1);
    smp(8'h3C, 8'h00, 8'h81);
    chk(brk_state == 2 && !dbg_irq, "R9", brk_state, 2);
    smp(8'h3C, 8'h00, 8'h00);
    chk(brk_state == 2 && !dbg_irq, "R9", brk_state, 2);
    smp(8'h00, 8'h00, 8'hF1);
    chk(brk_state == 3 && dbg_irq, "R9", {brk_state, dbg_irq}, 7);
    @(negedge clk);
    chk(!dbg_irq && brk_state == 3, "R10", dbg_irq, 0);

    // R12: rearm write coinciding with a matching sample
    wr(3'd0, ctl(4'b0100, 4'b0100, 4'b0000, 0, 2'd1));
    cfg_wr_en = 1; cfg_wr_addr = 3'd0; cfg_wr_data = ctl(4'b0100, 4'b0100, 4'b0000, 0, 2'd1);
    smp(8'h00, 8'h20, 8'h00);
    cfg_wr_en = 0;
    chk(brk_state == 1 && !halt_req, "R12", {brk_state, halt_req}, 2);
    smp(8'h00, 8'h20, 8'h00);
    chk(brk_state == 3 && halt_req, "R12", brk_state, 3);
    // R12: write from triggered rearms
    wr(3'd0, ctl(4'b0100, 4'b0100, 4'b0000, 0, 2'd1));
    chk(brk_state == 1, "R12", brk_state, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule